// File: doc/BRIEF.md
# Configuration Packet Stream Serializer

This block assembles a 32-bit configuration word stream from two inputs: a stream of packet descriptors and a separate stream of payload words. After reset it sends a fixed six-word preamble. The preamble first lets the receiver detect the bus width and then synchronise to word boundaries. After the preamble, each descriptor produces one encoded header word. The header is followed by as many payload words as the packet calls for, taken from the payload stream in arrival order.

Each descriptor holds four fields: a packet type, an opcode, a register address and a word count. It also carries a flag that marks it as the final packet of the list. Type 1 and type 2 use different header layouts. Type 0 and unknown types produce one header word and take no payload. All three streams use valid/ready handshakes. The output is registered and raises a last flag on the final word of the flagged packet. The block then goes quiet until the next reset.

Top module: `cfg_stream_serializer`

## Requirements
- R1: After reset, before any descriptor is accepted, the output carries six words in this order: FFFFFFFF, 000000BB, 11220044, FFFFFFFF, FFFFFFFF, AA995566 (hex). These are sent even if no descriptor ever arrives, and the output then stays idle.
- R2: A type-1 header (type code 1) is laid out as follows: type in bits 31:29, opcode in bits 28:27, register address in bits 26:13, and the low 11 bits of the word count in bits 10:0. Bits 12:11 are zero. For example, opcode 2, address 3 and count 2 give 30006002 (hex).
- R3: A type-2 header (type code 2) has the type in bits 31:29, the opcode in bits 28:27 and the full 27-bit word count in bits 26:0. It carries no address. For example, opcode 1 and count 12 give 4800000C (hex).
- R4: A type-0 descriptor yields a single all-zero word and consumes no payload, whatever its count field holds.
- R5: A descriptor of type 3 to 7 yields one word that holds only the type in bits 31:29 and consumes no payload.
- R6: After the header, a type-1 packet sends the number of payload words given by the low 11 bits of its count, and a type-2 packet sends the number given by its full count. The words pass through unchanged and in arrival order.
- R7: A type-1 or type-2 packet whose payload count is zero sends only its header word.
- R8: Packets leave in the order they were supplied, with no extra words between them. When inputs and output are always ready, one word is sent every cycle.
- R9: While the output is valid and not accepted, the output word, its valid and its last flag all stay unchanged.
- R10: out_last is high only on the final word of the packet whose descriptor had the final flag set. After that word is accepted, no further descriptor or payload is taken and nothing more is sent.
- R11: The payload input is ready only while a packet still has payload words to send. The descriptor input and the payload input are never ready in the same cycle.
- R12: While reset is high, and on the first cycle after it, the output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Descriptor taken this cycle if valid |
| desc_kind | input | 3 | Packet type code |
| desc_op | input | 2 | Opcode |
| desc_reg | input | 14 | Register address (type 1 only) |
| desc_len | input | 27 | Word count |
| desc_final | input | 1 | This descriptor is the final packet |
| pay_valid | input | 1 | Payload word present |
| pay_ready | output | 1 | Payload word taken this cycle if valid |
| pay_word | input | 32 | Payload word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 32 | Configuration stream word |
| out_last | output | 1 | Final word of the stream |

## Verification
The acceptance of the current output word by the consumer can fall in the same cycle as a descriptor or payload word being pulled in to replace it. This is because input readiness follows out_ready combinationally through the registered output stage. The bench provokes this overlap by running the same packet list under three consumer patterns (always ready, alternating, and pseudo-random), with gapped input valids in the last pattern. It judges the result by comparing every accepted word and last flag against an arithmetically built expected stream, checking that each held word stays unchanged and confirming a gapless word-per-cycle rate in the always-ready run.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int WORD_W     = 32;
  localparam int KIND_W     = 3;
  localparam int OP_W       = 2;
  localparam int REG_W      = 14;
  localparam int CNT_W      = 27;
  localparam int SHORT_W    = 11;
  localparam int PRE_LEN    = 6;
  localparam int PRE_IDX_W  = $clog2(PRE_LEN);

  localparam logic [KIND_W-1:0] KIND_PAD  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_ADDR = 3'd1;
  localparam logic [KIND_W-1:0] KIND_BULK = 3'd2;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_DONE = 2'd3
  } ser_state_e;
endpackage

// File: rtl/cfgser_preamble.sv
module cfgser_preamble
  import cfgser_pkg::*;
(
  input  logic [PRE_IDX_W-1:0] idx,
  output logic [WORD_W-1:0]    word
);
  always_comb begin
    case (idx)
      3'd0:    word = 32'hFFFF_FFFF;
      3'd1:    word = 32'h0000_00BB;
      3'd2:    word = 32'h1122_0044;
      3'd3:    word = 32'hFFFF_FFFF;
      3'd4:    word = 32'hFFFF_FFFF;
      3'd5:    word = 32'hAA99_5566;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/cfgser_hdr_enc.sv
module cfgser_hdr_enc
  import cfgser_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [OP_W-1:0]   op,
  input  logic [REG_W-1:0]  regaddr,
  input  logic [CNT_W-1:0]  len,
  output logic [WORD_W-1:0] hdr,
  output logic [CNT_W-1:0]  pay_cnt
);
  localparam int GAP_W = WORD_W - KIND_W - OP_W - REG_W - SHORT_W;

  always_comb begin
    case (kind)
      KIND_PAD: begin
        hdr     = '0;
        pay_cnt = '0;
      end
      KIND_ADDR: begin
        hdr     = {kind, op, regaddr, {GAP_W{1'b0}}, len[SHORT_W-1:0]};
        pay_cnt = {{(CNT_W-SHORT_W){1'b0}}, len[SHORT_W-1:0]};
      end
      KIND_BULK: begin
        hdr     = {kind, op, len};
        pay_cnt = len;
      end
      default: begin
        hdr     = {kind, {(WORD_W-KIND_W){1'b0}}};
        pay_cnt = '0;
      end
    endcase
  end
endmodule

// File: rtl/cfgser_out_stage.sv
module cfgser_out_stage
  import cfgser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d_word,
  input  logic              d_last,
  input  logic              out_ready,
  output logic              can_load,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= d_word;
      out_last  <= d_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // R9: a word waiting for the consumer stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

  // R12: output is idle right after reset
  a_r12_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/cfg_stream_serializer.sv
module cfg_stream_serializer
  import cfgser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [2:0]        desc_kind,
  input  logic [1:0]        desc_op,
  input  logic [13:0]       desc_reg,
  input  logic [26:0]       desc_len,
  input  logic              desc_final,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [31:0]       pay_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic              out_last
);
  ser_state_e             st_q;
  logic [PRE_IDX_W-1:0]   pre_idx_q;
  logic [CNT_W-1:0]       rem_q;
  logic                   fin_q;
  logic                   can_load;
  logic [WORD_W-1:0]      pre_word;
  logic [WORD_W-1:0]      hdr_word;
  logic [CNT_W-1:0]       hdr_cnt;
  logic                   ld;
  logic [WORD_W-1:0]      ld_word;
  logic                   ld_last;
  logic                   desc_fire;
  logic                   pay_fire;

  cfgser_preamble u_pre (
    .idx  (pre_idx_q),
    .word (pre_word)
  );

  cfgser_hdr_enc u_enc (
    .kind    (desc_kind),
    .op      (desc_op),
    .regaddr (desc_reg),
    .len     (desc_len),
    .hdr     (hdr_word),
    .pay_cnt (hdr_cnt)
  );

  assign desc_ready = (st_q == ST_HDR) && can_load;
  assign pay_ready  = (st_q == ST_PAY) && can_load;
  assign desc_fire  = desc_valid && desc_ready;
  assign pay_fire   = pay_valid && pay_ready;

  always_comb begin
    ld      = 1'b0;
    ld_word = '0;
    ld_last = 1'b0;
    case (st_q)
      ST_PRE: begin
        ld      = can_load;
        ld_word = pre_word;
      end
      ST_HDR: begin
        ld      = desc_fire;
        ld_word = hdr_word;
        ld_last = desc_final && (hdr_cnt == '0);
      end
      ST_PAY: begin
        ld      = pay_fire;
        ld_word = pay_word;
        ld_last = fin_q && (rem_q == CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_PRE;
      pre_idx_q <= '0;
      rem_q     <= '0;
      fin_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_PRE: if (can_load) begin
          if (pre_idx_q == PRE_IDX_W'(PRE_LEN - 1)) st_q <= ST_HDR;
          else pre_idx_q <= pre_idx_q + 1'b1;
        end
        ST_HDR: if (desc_fire) begin
          rem_q <= hdr_cnt;
          fin_q <= desc_final;
          if (hdr_cnt != '0) st_q <= ST_PAY;
          else if (desc_final) st_q <= ST_DONE;
        end
        ST_PAY: if (pay_fire) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) st_q <= fin_q ? ST_DONE : ST_HDR;
        end
        default: ;
      endcase
    end
  end

  cfgser_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .d_word    (ld_word),
    .d_last    (ld_last),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_last  (out_last)
  );

  // R11: only one input side may be pulled from at a time
  a_r11_one_side: assert property (@(posedge clk) disable iff (rst)
    !(desc_ready && pay_ready));

  // R1: no descriptor is taken while the preamble is still going out
  a_r1_pre_first: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRE) |-> !desc_ready);

  // R4: a type-0 descriptor becomes an all-zero word
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
    desc_fire && (desc_kind == KIND_PAD) |=> out_valid && (out_word == '0));

  // R6: payload words reach the output unchanged
  a_r6_pass: assert property (@(posedge clk) disable iff (rst)
    pay_fire |=> out_valid && (out_word == $past(pay_word)));

  // R10: after the final word leaves, both inputs stay closed
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !desc_ready && !pay_ready);
endmodule

// File: tb/sim_cfg_stream_serializer.sv
`timescale 1ns/1ps
module sim_cfg_stream_serializer;
  logic clk = 0;
  logic rst = 1;
  logic desc_valid = 0, desc_ready, desc_final = 0;
  logic [2:0] desc_kind = 0;
  logic [1:0] desc_op = 0;
  logic [13:0] desc_reg = 0;
  logic [26:0] desc_len = 0;
  logic pay_valid = 0, pay_ready;
  logic [31:0] pay_word = 0;
  logic out_valid, out_ready = 0, out_last;
  logic [31:0] out_word;

  always #5 clk = ~clk;

  cfg_stream_serializer u0 (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_kind(desc_kind),
    .desc_op(desc_op), .desc_reg(desc_reg), .desc_len(desc_len), .desc_final(desc_final),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_word(pay_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_last(out_last)
  );

  int total = 0, bad = 0;
  int nd, ne, np;
  bit has_fin;
  int dk[0:63], dop[0:63], dad[0:63], dln[0:63];
  bit dfin[0:63];
  logic [31:0] ew[0:4095];
  string er[0:4095];
  logic [31:0] pw[0:4095];
  int span;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_list();
    logic [31:0] pre[6] = '{32'hFFFFFFFF, 32'h000000BB, 32'h11220044,
                            32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAA995566};
    nd = 0; ne = 0; np = 0; has_fin = 0;
    for (int i = 0; i < 6; i++) begin ew[ne] = pre[i]; er[ne] = "R1 preamble"; ne++; end
  endtask

  task automatic add_pkt(int k, int op, int ad, int ln, bit fin);
    logic [31:0] h;
    int cnt;
    string tag;
    if (k == 0) begin h = 0; cnt = 0; tag = "R4 pad"; end
    else if (k == 1) begin
      cnt = ln % 2048;
      h = (32'd1 << 29) + (op << 27) + (ad << 13) + cnt;
      tag = (cnt == 0) ? "R7 empty type1" : "R2 type1 header";
    end else if (k == 2) begin
      cnt = ln;
      h = (32'd2 << 29) + (op << 27) + ln;
      tag = (cnt == 0) ? "R7 empty type2" : "R3 type2 header";
    end else begin h = k << 29; cnt = 0; tag = "R5 other type"; end
    dk[nd] = k; dop[nd] = op; dad[nd] = ad; dln[nd] = ln; dfin[nd] = fin; nd++;
    ew[ne] = h; er[ne] = tag; ne++;
    for (int w = 0; w < cnt; w++) begin
      pw[np] = 32'h5A00_0000 + np * 7 + 1;
      ew[ne] = pw[np]; er[ne] = "R6 payload order"; ne++; np++;
    end
    if (fin) has_fin = 1;
  endtask

  task automatic do_reset();
    rst = 1; desc_valid = 0; pay_valid = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R12 idle in reset", {31'b0, out_valid}, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && desc_ready == 0, "R12/R1 first cycle after reset",
        {30'b0, out_valid, desc_ready}, 0);
  endtask

  task automatic feed_desc(int mode);
    logic [7:0] l = 8'h3C;
    @(posedge clk); #1;
    for (int i = 0; i < nd; i++) begin
      l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
      if (mode == 2 && l[0]) begin desc_valid = 0; @(posedge clk); #1; end
      desc_valid = 1; desc_kind = 3'(dk[i]); desc_op = 2'(dop[i]);
      desc_reg = 14'(dad[i]); desc_len = 27'(dln[i]); desc_final = dfin[i];
      forever begin @(negedge clk); if (desc_valid && desc_ready) break; end
      @(posedge clk); #1;
    end
    desc_valid = 0;
  endtask

  task automatic feed_pay(int mode);
    logic [7:0] l = 8'hC3;
    @(posedge clk); #1;
    for (int i = 0; i < np; i++) begin
      l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
      if (mode == 2 && l[1]) begin pay_valid = 0; @(posedge clk); #1; end
      pay_valid = 1; pay_word = pw[i];
      forever begin @(negedge clk); if (pay_valid && pay_ready) break; end
      @(posedge clk); #1;
    end
    pay_valid = 0;
  endtask

  task automatic consume(int mode);
    logic [7:0] l = 8'hA5;
    int idx = 0, first = -1, cyc = 0;
    bit held = 0, tog = 0;
    logic [31:0] hw;
    logic hl;
    while (idx < ne) begin
      @(posedge clk); #1;
      l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
      tog = ~tog;
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? tog : l[2];
      @(negedge clk);
      cyc++;
      if (held) begin
        chk(out_valid && out_word == hw && out_last == hl, "R9 stalled word held", out_word, hw);
        held = 0;
      end
      if (out_valid && out_ready) begin
        if (first < 0) first = cyc;
        chk(out_word == ew[idx], er[idx], out_word, ew[idx]);
        chk(out_last == (has_fin && idx == ne - 1), "R10 last flag",
            {31'b0, out_last}, {31'b0, (has_fin && idx == ne - 1)});
        idx++;
        span = cyc - first;
      end else if (out_valid) begin
        held = 1; hw = out_word; hl = out_last;
      end
    end
    @(posedge clk); #1 out_ready = 1;
  endtask

  task automatic run_list(int mode);
    fork
      feed_desc(mode);
      feed_pay(mode);
      consume(mode);
    join
  endtask

  task automatic tail_quiet(string req);
    desc_valid = 1; desc_kind = 1; desc_len = 1; pay_valid = 1; out_ready = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!out_valid && !desc_ready && !pay_ready, req,
          {29'b0, out_valid, desc_ready, pay_ready}, 0);
    end
    @(posedge clk); #1 desc_valid = 0; pay_valid = 0;
  endtask

  task automatic build_sweep();
    start_list();
    for (int k = 0; k < 32; k++)
      add_pkt(k % 8, k % 4, (k * 37) % 16384, k / 8, k == 31);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: preamble with no descriptors, then idle; R11 payload ignored
    do_reset();
    start_list();
    run_list(0);
    desc_valid = 0; pay_valid = 1; pay_word = 32'hDEAD_BEEF;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!out_valid && !pay_ready, "R11 payload ignored when idle (R1 stall)",
          {30'b0, out_valid, pay_ready}, 0);
    end
    @(posedge clk); #1 pay_valid = 0;

    // Fixed examples and boundaries, always ready: R2 R3 R4 R5 R7 R8
    do_reset();
    start_list();
    add_pkt(1, 2, 3, 2, 0);          // 30006002
    add_pkt(1, 2, 3, 0, 0);          // header only
    add_pkt(2, 1, 0, 12, 0);         // 4800000C
    add_pkt(0, 3, 99, 5, 0);         // zero word, no payload
    add_pkt(5, 3, 77, 4, 0);         // type bits only
    add_pkt(1, 1, 16383, 2047, 0);   // widest short count
    add_pkt(1, 0, 5, 2048 + 1, 0);   // count above 11 bits truncates to 1
    add_pkt(2, 3, 0, 0, 0);          // empty type 2
    add_pkt(1, 3, 16383, 3, 1);      // final
    chk(ew[6] == 32'h30006002, "R2 example value", ew[6], 32'h30006002);
    run_list(0);
    chk(span == ne - 1, "R8 one word per cycle", span, ne - 1);
    tail_quiet("R10 quiet after last");

    // Sweep all types x counts 0..3 under three consumer patterns
    for (int m = 0; m < 3; m++) begin
      do_reset();
      build_sweep();
      run_list(m);
      tail_quiet("R10 quiet after last (sweep)");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule